// File: doc/BRIEF.md
# High-Speed Bus Mode Entry Detector

This block sits next to a two-wire (I2C) slave and watches the clock and data lines without ever driving them. It recognises start, repeated start and stop conditions. It captures the byte that follows each start and looks for the high-speed master code, whose upper five bits are `00001` and whose low three bits may take any value. No device answers that code, so a valid entry shows a not-acknowledge on the ninth clock and then a repeated start. At that repeated start the block raises `hs_mode`. The slave uses this flag to switch to high-speed timing, for example by narrowing its input spike filter from 50 ns to 10 ns. The address byte that follows is therefore already received with the high-speed setting.

Once raised, the flag holds through any number of later repeated starts and transfers. It falls only at a stop condition or at reset. The bus inputs are asynchronous, so they pass through a synchroniser of configurable depth before any condition is decoded.

Top module: `hs_entry_detect`

## Requirements
- R1: Reset (synchronous, active high) clears `hs_mode` to 0, also while a high-speed transfer is in progress.
- R2: A first byte after a start whose bits 7..3 are `00001`, followed by a ninth-clock SDA level of 1 (not-acknowledge) and then a repeated start, sets `hs_mode` to 1 at that repeated start, before the next byte begins. `hs_mode` stays 0 between the not-acknowledge and the repeated start.
- R3: The low three bits (bits 2..0) of the master code do not affect recognition.
- R4: If SDA is 0 on the ninth clock after the master code, entry is abandoned and a following repeated start leaves `hs_mode` at 0.
- R5: A master code followed by a stop instead of a repeated start leaves `hs_mode` at 0. A later normal transfer does not raise it either.
- R6: While `hs_mode` is 1, further repeated starts and bytes of any value keep it at 1.
- R7: A stop condition (SDA rising while SCL is high) returns `hs_mode` to 0.
- R8: A first byte whose bits 7..3 differ from `00001` (for example 0x18, 0x07 or 0x10) never leads to `hs_mode` = 1, whatever the ninth bit is and whether or not a repeated start follows.
- R9: The code is recognised only in the first byte after a start. The same value sent as a later data byte, even with a not-acknowledge and a repeated start after it, leaves `hs_mode` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_in | input | 1 | Bus clock line level, asynchronous |
| sda_in | input | 1 | Bus data line level, asynchronous |
| hs_mode | output | 1 | 1 while the bus is in high-speed mode |

## Verification
The bench builds the block with a three-stage synchroniser rather than the default two. This adds a cycle of latency between a line edge and its decoded condition, and shows that none of the mode decisions depend on a fixed pipeline depth. Each bus quarter-period lasts six system clocks. This is only just longer than the synchroniser plus decode path, so the check taken halfway through the address byte shows that the flag is already set before the slave samples address bits.

// File: rtl/hsd_pkg.sv
package hsd_pkg;

    // Upper five bits that mark the high-speed master code
    localparam int          MC_PREFIX_W = 5;
    localparam logic [4:0]  MC_PREFIX   = 5'b00001;

    typedef enum logic [2:0] {
        ST_IDLE,   // no transfer in progress, fast/standard timing
        ST_FIRST,  // receiving the first byte after a start
        ST_ARMED,  // master code and NACK seen, waiting for repeated start
        ST_PASS,   // ordinary transfer, ignore data until next condition
        ST_HS      // high-speed mode until stop
    } hsd_state_e;

    typedef struct packed {
        logic start;     // start or repeated start
        logic stop;      // stop
        logic scl_rise;  // data/ack sampling edge
        logic sda;       // synchronised data level
    } bus_ev_t;

    function automatic logic is_master_code(input logic [7:0] b);
        return b[7 -: MC_PREFIX_W] == MC_PREFIX;
    endfunction

endpackage

// File: rtl/hsd_sync.sv
module hsd_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Bus lines idle high, so every stage resets high
    logic [W-1:0] pipe [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) pipe[0] <= '1;
                    else     pipe[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) pipe[i] <= '1;
                    else     pipe[i] <= pipe[i-1];
                end
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/hsd_cond.sv
module hsd_cond
    import hsd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_s,
    input  logic    sda_s,
    output bus_ev_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        ev.start    = scl_q & scl_s & sda_q & ~sda_s;
        ev.stop     = scl_q & scl_s & ~sda_q & sda_s;
        ev.scl_rise = ~scl_q & scl_s;
        ev.sda      = sda_s;
    end
endmodule

// File: rtl/hsd_shift.sv
module hsd_shift
    import hsd_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    output logic [BYTE_W-1:0] byte_q,
    output logic              ninth_done,
    output logic              ninth_bit
);
    localparam int FRAME = BYTE_W + 1;
    localparam int CNT_W = $clog2(FRAME + 1);

    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            shreg <= '0;
        end else if (ev.start || ev.stop) begin
            cnt <= '0;
        end else if (ev.scl_rise) begin
            if (cnt == CNT_W'(FRAME - 1)) cnt <= '0;
            else                          cnt <= cnt + 1'b1;
            if (cnt < CNT_W'(BYTE_W))
                shreg <= {shreg[BYTE_W-2:0], ev.sda};
        end
    end

    assign byte_q     = shreg;
    assign ninth_done = ev.scl_rise && (cnt == CNT_W'(FRAME - 1));
    assign ninth_bit  = ev.sda;

    // R9
    cnt_restart_chk: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> cnt == '0);
endmodule

// File: rtl/hs_entry_detect.sv
module hs_entry_detect
    import hsd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BYTE_W      = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic hs_mode
);
    logic [1:0]        lines_s;
    bus_ev_t           ev;
    logic [BYTE_W-1:0] first_byte;
    logic              ninth_done, ninth_bit;
    hsd_state_e        state, state_nx;
    logic              hs_set, hs_clr;

    hsd_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
        .clk(clk), .rst(rst), .d({scl_in, sda_in}), .q(lines_s)
    );

    hsd_cond u_cond (
        .clk(clk), .rst(rst), .scl_s(lines_s[1]), .sda_s(lines_s[0]), .ev(ev)
    );

    hsd_shift #(.BYTE_W(BYTE_W)) u_shift (
        .clk(clk), .rst(rst), .ev(ev), .byte_q(first_byte),
        .ninth_done(ninth_done), .ninth_bit(ninth_bit)
    );

    always_comb begin
        state_nx = state;
        hs_set   = 1'b0;
        hs_clr   = 1'b0;
        unique case (state)
            ST_IDLE:  if (ev.start) state_nx = ST_FIRST;
            ST_FIRST: begin
                if (ev.stop)       state_nx = ST_IDLE;
                else if (ev.start) state_nx = ST_FIRST;
                else if (ninth_done)
                    state_nx = (is_master_code(first_byte[7:0]) && ninth_bit)
                               ? ST_ARMED : ST_PASS;
            end
            ST_ARMED: begin
                if (ev.stop) state_nx = ST_IDLE;
                else if (ev.start) begin
                    state_nx = ST_HS;
                    hs_set   = 1'b1;
                end
            end
            ST_PASS: begin
                if (ev.stop)       state_nx = ST_IDLE;
                else if (ev.start) state_nx = ST_FIRST;
            end
            ST_HS: begin
                if (ev.stop) begin
                    state_nx = ST_IDLE;
                    hs_clr   = 1'b1;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            hs_mode <= 1'b0;
        end else begin
            state <= state_nx;
            if (hs_clr)      hs_mode <= 1'b0;
            else if (hs_set) hs_mode <= 1'b1;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> !hs_mode);

    // R2
    rise_on_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_mode) |-> $past(ev.start));

    // R4
    ack_abandon_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FIRST && ninth_done && !ninth_bit && !ev.start && !ev.stop)
        |=> state == ST_PASS);

    // R6
    hs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (hs_mode && !ev.stop) |=> hs_mode);

    // R7
    stop_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> !hs_mode);
endmodule

// File: tb/hs_entry_detect_test.sv
module hs_entry_detect_test;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda = 1'b1;
    logic hs_mode;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic  exp;
        string req;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    hs_entry_detect #(.SYNC_STAGES(3), .BYTE_W(8)) uut (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda), .hs_mode(hs_mode)
    );

    // Monitor: pops expectations and compares away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (hs_mode !== e.exp) begin
                    fails++;
                    $display("FAIL %s: hs_mode actual %0b expected %0b", e.req, hs_mode, e.exp);
                end
            end
        end
    end

    task automatic wq(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic expect_mode(input logic v, input string req);
        exp_t e;
        wq(Q);
        e.exp = v;
        e.req = req;
        sb.push_back(e);
        while (sb.size() > 0) @(posedge clk);
    endtask

    task automatic bus_start();
        sda = 1'b0; wq(Q);
        scl = 1'b0; wq(Q);
    endtask

    task automatic rep_start();
        sda = 1'b1; wq(Q);
        scl = 1'b1; wq(Q);
        sda = 1'b0; wq(Q);
        scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda = 1'b0; wq(Q);
        scl = 1'b1; wq(Q);
        sda = 1'b1; wq(2*Q);
    endtask

    task automatic send_bit(input logic b);
        sda = b;    wq(Q);
        scl = 1'b1; wq(2*Q);
        scl = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic ninth);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        send_bit(ninth);
    endtask

    initial begin
        wq(5);
        rst = 1'b0;
        expect_mode(1'b0, "R1");

        // Valid entry: code 0x08, NACK, repeated start, address
        bus_start();
        send_byte(8'h08, 1'b1);
        expect_mode(1'b0, "R2");
        rep_start();
        expect_mode(1'b1, "R2");
        for (int i = 7; i >= 4; i--) send_bit(1'b0);
        expect_mode(1'b1, "R2");
        for (int i = 3; i >= 0; i--) send_bit(1'b1);
        send_bit(1'b0);
        send_byte(8'h08, 1'b1);
        rep_start();
        send_byte(8'hA5, 1'b0);
        expect_mode(1'b1, "R6");
        rep_start();
        send_byte(8'h0C, 1'b1);
        expect_mode(1'b1, "R6");
        bus_stop();
        expect_mode(1'b0, "R7");

        // Don't-care low bits
        bus_start();
        send_byte(8'h0D, 1'b1);
        rep_start();
        expect_mode(1'b1, "R3");
        bus_stop();
        expect_mode(1'b0, "R7");
        bus_start();
        send_byte(8'h0F, 1'b1);
        rep_start();
        expect_mode(1'b1, "R3");
        bus_stop();

        // Acknowledged master code
        bus_start();
        send_byte(8'h09, 1'b0);
        rep_start();
        expect_mode(1'b0, "R4");
        send_byte(8'h30, 1'b0);
        expect_mode(1'b0, "R4");
        bus_stop();

        // Master code then stop
        bus_start();
        send_byte(8'h0A, 1'b1);
        bus_stop();
        expect_mode(1'b0, "R5");
        bus_start();
        send_byte(8'h18, 1'b0);
        rep_start();
        expect_mode(1'b0, "R5");
        bus_stop();

        // Non-matching first bytes
        bus_start();
        send_byte(8'h18, 1'b1);
        rep_start();
        expect_mode(1'b0, "R8");
        send_byte(8'h07, 1'b1);
        rep_start();
        expect_mode(1'b0, "R8");
        send_byte(8'h10, 1'b1);
        rep_start();
        expect_mode(1'b0, "R8");
        bus_stop();

        // Code as a later data byte
        bus_start();
        send_byte(8'h18, 1'b0);
        send_byte(8'h0B, 1'b1);
        rep_start();
        expect_mode(1'b0, "R9");
        bus_stop();

        // Reset during high-speed mode
        bus_start();
        send_byte(8'h08, 1'b1);
        rep_start();
        expect_mode(1'b1, "R2");
        rst = 1'b1;
        wq(3);
        rst = 1'b0;
        expect_mode(1'b0, "R1");
        bus_stop();
        expect_mode(1'b0, "R1");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule